// File: doc/BRIEF.md
# Handshaked Dead-Time Inserter

This block drives one half-bridge phase. A single PWM command selects which of the two power switches should conduct. The block turns that command into two gate enables, one for the high side and one for the low side, and the two are never on together. When the command changes, the conducting switch is turned off first. The block then waits for a comparator flag showing that the gate-source voltage of that switch has fallen below its cutoff threshold. Only after this confirmation does it count a programmable digital dead time, and only when the count ends does it enable the opposite switch.

The dead time is added to whatever time the handshake takes. It is never overlapped with the handshake. A 3-bit code sets the dead time. At the intended 100 MHz clock, code 0 gives 40 ns and each step adds the same amount. A global disable forces both gates off in the same cycle and sends the sequencer back to idle. Each time a gate enable rises, the block emits a one-cycle strobe so that a separate overcurrent monitor can start its blanking window while the dead-time timer runs.

Top module: `hb_deadtime_gen`

## Requirements
- R1: `hs_en` and `ls_en` are never both high in any cycle.
- R2: While `rst_n` is low, `hs_en`, `ls_en` and `on_strobe` are low. After reset is released, the block makes its first turn-on toward the side that `pwm_cmd` selects (1 = high side, 0 = low side), using the same handshake and dead-time sequence as any other turn-on.
- R3: The incoming gate is not enabled while the outgoing gate's below-threshold flag (`ls_gate_low` when turning the high side on, `hs_gate_low` when turning the low side on) stays 0, however long that lasts.
- R4: The dead time starts on the clock edge that samples the outgoing flag at 1. The incoming enable rises exactly N clock edges after that edge. As a result, with the flag already at 1, the enable rises N+2 cycles after the command changes, and every cycle of delay on the flag adds one more cycle.
- R5: The dead-time length is N = 4 + 4*c cycles, where c is the unsigned value of `dt_code` at the handshake. Code 0 gives 4 cycles and code 7 gives 32 cycles.
- R6: While `drv_disable` is high, both enables and `on_strobe` are low in that same cycle. This holds even if a dead time expires in that cycle. After release, the next turn-on rises N+2 cycles later.
- R7: If `pwm_cmd` reverses during the handshake wait or the dead time, the pending turn-on is dropped and never appears. The sequence restarts toward the new side, and that side's enable rises N+2 cycles after the reversal.
- R8: `on_strobe` is high for exactly one cycle, in the same cycle that `hs_en` or `ls_en` rises. It is low in every other cycle.
- R9: While `pwm_cmd` is steady, an enabled gate stays on regardless of changes on either comparator flag, and no strobe is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwm_cmd | input | 1 | Side to conduct: 1 high, 0 low |
| hs_gate_low | input | 1 | High-side gate-source below cutoff |
| ls_gate_low | input | 1 | Low-side gate-source below cutoff |
| dt_code | input | 3 | Dead-time code |
| drv_disable | input | 1 | Global disable, forces both gates off |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| on_strobe | output | 1 | One-cycle pulse on any gate turn-on |

## Verification
The dead-time expiry and the global disable can both act in one cycle. If they do, either an enable rises together with its strobe, or the disable wins and nothing rises. The bench provokes this by raising `drv_disable` in the exact cycle in which the timer reaches its end. It then requires that neither enable nor the strobe appears in the following cycle. It also requires that, after release, a full handshake and dead time is counted again before the enable rises. A reversal of `pwm_cmd` in the middle of a dead time is exercised in the same way, and the bench checks that the abandoned side never turns on.

// File: rtl/hb_dt_pkg.sv
package hb_dt_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HSHK = 2'd1,
    PH_DEAD = 2'd2,
    PH_ON   = 2'd3
  } ph_state_e;

  // Dead-time length in clock cycles for a given code.
  function automatic int unsigned dt_cycles(input int unsigned code,
                                            input int unsigned base,
                                            input int unsigned step);
    return base + code * step;
  endfunction

endpackage

// File: rtl/hb_dt_timer.sv
module hb_dt_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/hb_phase_fsm.sv
module hb_phase_fsm
  import hb_dt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_cmd,
  input  logic hs_gate_low,
  input  logic ls_gate_low,
  input  logic drv_disable,
  input  logic dt_done,
  output logic dt_load,
  output logic hshk_ok,
  output logic cancel,
  output logic on_hi,
  output logic on_lo
);

  ph_state_e st_q, st_d;
  logic      tgt_q, tgt_d;
  logic      out_below;

  always_comb begin
    // The flag of the switch that is going off, relative to the target side.
    out_below = tgt_q ? ls_gate_low : hs_gate_low;
    cancel    = ((st_q == PH_HSHK) || (st_q == PH_DEAD)) && (pwm_cmd != tgt_q);
    hshk_ok   = (st_q == PH_HSHK) && !cancel && out_below;
    dt_load   = hshk_ok && !drv_disable;

    st_d  = st_q;
    tgt_d = tgt_q;
    if (drv_disable) begin
      st_d = PH_IDLE;
    end else begin
      unique case (st_q)
        PH_IDLE: begin
          st_d  = PH_HSHK;
          tgt_d = pwm_cmd;
        end
        PH_HSHK: begin
          if (cancel) begin
            tgt_d = pwm_cmd;
          end else if (hshk_ok) begin
            st_d = PH_DEAD;
          end
        end
        PH_DEAD: begin
          if (cancel) begin
            st_d  = PH_HSHK;
            tgt_d = pwm_cmd;
          end else if (dt_done) begin
            st_d = PH_ON;
          end
        end
        PH_ON: begin
          if (pwm_cmd != tgt_q) begin
            st_d  = PH_HSHK;
            tgt_d = pwm_cmd;
          end
        end
        default: st_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PH_IDLE;
      tgt_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      tgt_q <= tgt_d;
    end
  end

  assign on_hi = (st_q == PH_ON) &&  tgt_q;
  assign on_lo = (st_q == PH_ON) && !tgt_q;

endmodule

// File: rtl/hb_gate_out.sv
module hb_gate_out (
  input  logic clk,
  input  logic rst_n,
  input  logic on_hi,
  input  logic on_lo,
  input  logic drv_disable,
  output logic hs_en,
  output logic ls_en,
  output logic on_strobe
);

  logic hs_prev_q, ls_prev_q;

  assign hs_en = on_hi && !drv_disable;
  assign ls_en = on_lo && !drv_disable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_prev_q <= 1'b0;
      ls_prev_q <= 1'b0;
    end else begin
      hs_prev_q <= hs_en;
      ls_prev_q <= ls_en;
    end
  end

  assign on_strobe = (hs_en && !hs_prev_q) || (ls_en && !ls_prev_q);

endmodule

// File: rtl/hb_deadtime_gen.sv
module hb_deadtime_gen #(
  parameter int CODE_W   = 3,
  parameter int BASE_CYC = 4,
  parameter int STEP_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwm_cmd,
  input  logic              hs_gate_low,
  input  logic              ls_gate_low,
  input  logic [CODE_W-1:0] dt_code,
  input  logic              drv_disable,
  output logic              hs_en,
  output logic              ls_en,
  output logic              on_strobe
);

  localparam int MAX_CYC = BASE_CYC + ((1 << CODE_W) - 1) * STEP_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic             dt_load, dt_done, hshk_ok, cancel, on_hi, on_lo;
  logic [CNT_W-1:0] load_val;

  // The timer counts down to zero, so it is loaded with the length minus one.
  assign load_val = CNT_W'(hb_dt_pkg::dt_cycles(32'(dt_code), BASE_CYC, STEP_CYC) - 1);

  hb_phase_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwm_cmd     (pwm_cmd),
    .hs_gate_low (hs_gate_low),
    .ls_gate_low (ls_gate_low),
    .drv_disable (drv_disable),
    .dt_done     (dt_done),
    .dt_load     (dt_load),
    .hshk_ok     (hshk_ok),
    .cancel      (cancel),
    .on_hi       (on_hi),
    .on_lo       (on_lo)
  );

  hb_dt_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (dt_load),
    .load_val (load_val),
    .done     (dt_done)
  );

  hb_gate_out u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .on_hi       (on_hi),
    .on_lo       (on_lo),
    .drv_disable (drv_disable),
    .hs_en       (hs_en),
    .ls_en       (ls_en),
    .on_strobe   (on_strobe)
  );

endmodule

// File: rtl/hb_dt_chk.sv
module hb_dt_chk #(
  parameter int BASE_CYC = 4
) (
  input logic clk,
  input logic rst_n,
  input logic hs_gate_low,
  input logic ls_gate_low,
  input logic drv_disable,
  input logic hs_en,
  input logic ls_en,
  input logic on_strobe,
  input logic cancel
);

  logic [15:0] off_cnt;
  logic        hs_seen_low, ls_seen_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_cnt     <= '0;
      hs_seen_low <= 1'b0;
      ls_seen_low <= 1'b0;
    end else begin
      off_cnt     <= (hs_en || ls_en) ? '0 : ((off_cnt == 16'hFFFF) ? off_cnt : off_cnt + 1'b1);
      hs_seen_low <= hs_en ? 1'b0 : (hs_seen_low || hs_gate_low);
      ls_seen_low <= ls_en ? 1'b0 : (ls_seen_low || ls_gate_low);
    end
  end

  a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_en && ls_en));

  a_r3_hs_after_ls_off: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en) |-> ls_seen_low);

  a_r3_ls_after_hs_off: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_en) |-> hs_seen_low);

  a_r4_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hs_en) || $rose(ls_en)) |-> (off_cnt >= 16'(BASE_CYC + 1)));

  a_r6_disable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    drv_disable |-> (!hs_en && !ls_en && !on_strobe));

  a_r7_cancel_off: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> (!hs_en && !ls_en));

  a_r8_strobe_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hs_en) || $rose(ls_en)) |-> on_strobe);

  a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    on_strobe |=> !on_strobe);

endmodule

bind hb_deadtime_gen hb_dt_chk #(.BASE_CYC(BASE_CYC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hs_gate_low (hs_gate_low),
  .ls_gate_low (ls_gate_low),
  .drv_disable (drv_disable),
  .hs_en       (hs_en),
  .ls_en       (ls_en),
  .on_strobe   (on_strobe),
  .cancel      (cancel)
);

// File: tb/test_hb_deadtime_gen.sv
module test_hb_deadtime_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwm_cmd = 1'b0;
  logic       hs_gate_low = 1'b1;
  logic       ls_gate_low = 1'b1;
  logic       drv_disable = 1'b0;
  logic [2:0] dt_code = 3'd0;
  logic       hs_en, ls_en, on_strobe;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  hb_deadtime_gen i_hb_deadtime_gen (
    .clk(clk), .rst_n(rst_n), .pwm_cmd(pwm_cmd), .hs_gate_low(hs_gate_low),
    .ls_gate_low(ls_gate_low), .dt_code(dt_code), .drv_disable(drv_disable),
    .hs_en(hs_en), .ls_en(ls_en), .on_strobe(on_strobe)
  );

  // target, code, flag delay, expected sample of the rise (4*(code+1) + 2 + delay)
  localparam int VEC [8][4] = '{
    '{1, 0, 0,  6}, '{0, 1, 0, 10}, '{1, 7, 0, 34}, '{0, 0, 3,  9},
    '{1, 3, 2, 20}, '{0, 5, 1, 27}, '{1, 2, 5, 19}, '{0, 6, 0, 30}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Watch from the current drive point until the target gate turns on.
  task automatic watch(input bit tgt, input int delay, output int k, output bit opp_seen);
    opp_seen = 1'b0;
    k = 0;
    for (int i = 1; i <= 200; i++) begin
      @(negedge clk);
      chk(!(hs_en && ls_en), "R1 overlap", int'(hs_en && ls_en), 0);
      if (tgt ? ls_en : hs_en) opp_seen = 1'b1;
      if (tgt ? hs_en : ls_en) begin
        k = i;
        chk(on_strobe == 1'b1, "R8 strobe at rise", int'(on_strobe), 1);
        break;
      end
      chk(on_strobe == 1'b0, "R8 strobe while off", int'(on_strobe), 0);
      if (i == delay + 1) begin
        if (tgt) ls_gate_low = 1'b1; else hs_gate_low = 1'b1;
      end
    end
    @(negedge clk);
    chk(on_strobe == 1'b0, "R8 strobe width", int'(on_strobe), 0);
    chk((tgt ? hs_en : ls_en) == 1'b1, "R9 gate held", int'(tgt ? hs_en : ls_en), 1);
  endtask

  task automatic xfer(input bit tgt, input int code, input int delay, input int exp, input string req);
    int  k;
    bit  opp;
    @(negedge clk);
    dt_code = 3'(code);
    if (tgt) ls_gate_low = 1'b0; else hs_gate_low = 1'b0;
    pwm_cmd = tgt;
    watch(tgt, delay, k, opp);
    chk(k == exp, req, k, exp);
  endtask

  initial begin
    int k;
    bit opp;
    // R2: reset state
    repeat (3) @(negedge clk);
    chk(!hs_en && !ls_en && !on_strobe, "R2 reset outputs", int'({hs_en, ls_en, on_strobe}), 0);
    rst_n = 1'b1;
    watch(1'b0, 0, k, opp);
    chk(k == 6, "R2 first turn-on low side", k, 6);

    // R4 / R5: table of transitions
    for (int v = 0; v < 8; v++) begin
      xfer(VEC[v][0] != 0, VEC[v][1], VEC[v][2], VEC[v][3], "R4 R5 transition timing");
    end

    // R3: outgoing flag held low for a long time
    xfer(1'b1, 0, 40, 46, "R3 handshake wait");

    // R9: comparator activity while on has no effect
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(hs_en && !ls_en && !on_strobe, "R9 steady on", int'({hs_en, ls_en, on_strobe}), 4);
      hs_gate_low = i[0];
      ls_gate_low = ~i[0];
    end
    @(negedge clk);
    hs_gate_low = 1'b1;
    ls_gate_low = 1'b1;

    // R7: reversal during the handshake wait
    @(negedge clk);
    dt_code = 3'd0;
    hs_gate_low = 1'b0;
    pwm_cmd = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(!hs_en && !ls_en, "R7 off during stuck handshake", int'({hs_en, ls_en}), 0);
    end
    pwm_cmd = 1'b1;
    watch(1'b1, 0, k, opp);
    chk(k == 6, "R7 restart after handshake reversal", k, 6);
    chk(!opp, "R7 cancelled low side", int'(opp), 0);
    hs_gate_low = 1'b1;

    // R7: reversal during the dead time
    @(negedge clk);
    dt_code = 3'd7;
    pwm_cmd = 1'b0;
    repeat (4) @(negedge clk);
    chk(!hs_en && !ls_en, "R7 off during dead time", int'({hs_en, ls_en}), 0);
    pwm_cmd = 1'b1;
    watch(1'b1, 0, k, opp);
    chk(k == 34, "R7 restart after dead-time reversal", k, 34);
    chk(!opp, "R7 cancelled low side in dead time", int'(opp), 0);

    // R6: disable while on, same-cycle effect
    @(negedge clk);
    dt_code = 3'd0;
    drv_disable = 1'b1;
    #1;
    chk(!hs_en && !ls_en && !on_strobe, "R6 immediate off", int'({hs_en, ls_en, on_strobe}), 0);
    repeat (3) begin
      @(negedge clk);
      chk(!hs_en && !ls_en && !on_strobe, "R6 held off", int'({hs_en, ls_en, on_strobe}), 0);
    end
    drv_disable = 1'b0;
    watch(1'b1, 0, k, opp);
    chk(k == 6, "R6 restart after release", k, 6);

    // R6: disable raised in the cycle the dead time expires
    @(negedge clk);
    pwm_cmd = 1'b0;
    repeat (5) @(negedge clk);
    chk(!ls_en, "R4 not yet on before expiry", int'(ls_en), 0);
    drv_disable = 1'b1;
    @(negedge clk);
    chk(!ls_en && !hs_en && !on_strobe, "R6 expiry masked", int'({hs_en, ls_en, on_strobe}), 0);
    drv_disable = 1'b0;
    watch(1'b0, 0, k, opp);
    chk(k == 6, "R6 full sequence after masked expiry", k, 6);

    // R2: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!hs_en && !ls_en && !on_strobe, "R2 reset while on", int'({hs_en, ls_en, on_strobe}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    watch(1'b0, 0, k, opp);
    chk(k == 6, "R2 restart after reset", k, 6);

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule